// File: doc/BRIEF.md
# Simultaneous-Sampling Converter Host Controller

This block sits on the host side of a six-channel serial converter whose channels are all sampled at the same instant. When the host asks for a conversion, the block raises a convert pulse. It then runs a serial clock burst of 16 clocks for each active channel and shifts the returned bit stream into one 12-bit word per channel. The converter always returns the results of the conversion before the current one. The controller accounts for this one-frame lag. A frame is published only when the data it carries was converted with the configuration that is active now.

The channel-count select and the polarity mode are requested on plain inputs. They reach the converter only through locked copies, which the block changes only while it is idle and only after two conversions have completed under the current setting. This keeps a setting in place for a conversion and for the following conversion that reads its data. After a change of polarity mode, the block waits a programmable number of cycles before it starts the next conversion. Finished frames leave through a valid/ready interface.

Back-pressure rule: a frame stays on `frm_data`, unchanged, until it is accepted. No new conversion starts while a frame is waiting, so a stalled consumer pauses conversions and no data is lost.

Top module: `adc_host_ctl`

## Requirements
- R1: After reset, `adc_conv`, `adc_sck`, `busy` and `frm_valid` are low, and the locked select and polarity are 0.
- R2: A conversion begins with `adc_conv` held high for CONV_HI clock cycles. A burst of 16·n rising edges on `adc_sck` follows, where n = select+1 for select values 0 to 4 and n = 6 for select values 5, 6 and 7.
- R3: `adc_sdo` is sampled on each rising edge of `adc_sck`. Each 16-bit slot belongs to one channel, channel 0 first. The first 12 bits of a slot form that channel's word, MSB first. Channel c appears at `frm_data[12c+11:12c]`, and inactive channels read 0.
- R4: A published frame holds the words returned during a burst, which are the samples of the conversion before it. The first conversion after reset, and the first after any configuration change, publishes no frame.
- R5: A requested change of select or polarity takes effect only after two conversions have completed with the current setting. `adc_sel` and `adc_bip` never change while `busy` is high.
- R6: After `adc_bip` changes, at least ACQ_WAIT clock cycles pass before `adc_conv` rises again.
- R7: `frm_valid` stays high, with `frm_data` unchanged, until `frm_ready` is high. `adc_conv` never rises while a frame is waiting.
- R8: `adc_conv` and `adc_sck` are never high together, and `adc_sck` is low whenever `busy` is low.
- R9: `frm_nch` and `frm_bip` report the channel count and the polarity under which the frame's data was converted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_req | input | 1 | Level request to start a conversion |
| cfg_sel | input | 3 | Requested channel-count select |
| cfg_bip | input | 1 | Requested polarity mode (1 = bipolar) |
| busy | output | 1 | A conversion and its burst are in progress |
| adc_conv | output | 1 | Convert pulse to the converter |
| adc_sck | output | 1 | Serial clock to the converter |
| adc_sdo | input | 1 | Serial data from the converter |
| adc_sel | output | 3 | Locked channel-count select to the converter |
| adc_bip | output | 1 | Locked polarity mode to the converter |
| frm_valid | output | 1 | Frame available |
| frm_ready | input | 1 | Consumer accepts the frame |
| frm_data | output | NCH·W | Channel words, channel 0 in the low bits |
| frm_nch | output | clog2(NCH+1) | Number of active channels in the frame |
| frm_bip | output | 1 | Polarity mode of the frame |

## Verification
Two functions can meet in one idle cycle: applying a deferred configuration and launching a requested conversion. The bench provokes this by changing `cfg_sel` or `cfg_bip` and raising `start_req` at the same moment after two conversions. It then judges the outcome from the burst length, which must match the new select, from the missing frame, and from the measured gap between the polarity change and the convert edge. The second meeting point is a frame acceptance that coincides with a pending start. Here the conversion must wait for the handshake, and the accepted frame must be the one that was held.

// File: rtl/adc_hc_pkg.sv
package adc_hc_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_CONV,
    SQ_BURST,
    SQ_DONE
  } seq_state_t;

  typedef struct packed {
    logic [2:0] sel;
    logic       bip;
  } adc_cfg_t;

  // active channel count for a select code, clipped to the channel limit
  function automatic int unsigned chan_count(input logic [2:0] sel,
                                             input int unsigned nmax);
    int unsigned n;
    n = 32'(sel) + 1;
    if (n > nmax) n = nmax;
    return n;
  endfunction

endpackage

// File: rtl/adc_hc_cfg.sv
module adc_hc_cfg
  import adc_hc_pkg::*;
#(
  parameter int ACQ_WAIT = 40
) (
  input  logic     clk,
  input  logic     rst_n,
  input  adc_cfg_t req,
  input  logic     seq_idle,
  input  logic     conv_done,
  output adc_cfg_t act,
  output logic     primed,
  output logic     hold
);
  localparam int AW = $clog2(ACQ_WAIT + 2);

  logic [1:0]    lock_cnt;
  logic [AW-1:0] acq_cnt;
  logic          differs;
  logic          free;
  logic          apply;

  assign differs = (req != act);
  assign free    = (lock_cnt == 2'd2);
  assign apply   = seq_idle && differs && free;
  assign hold    = (differs && free) || (acq_cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act      <= '0;
      lock_cnt <= 2'd2;
      primed   <= 1'b0;
      acq_cnt  <= '0;
    end else if (apply) begin
      act      <= req;
      lock_cnt <= 2'd0;
      primed   <= 1'b0;
      if (req.bip != act.bip) acq_cnt <= AW'(ACQ_WAIT);
    end else begin
      if (conv_done) begin
        primed <= 1'b1;
        if (!free) lock_cnt <= lock_cnt + 2'd1;
      end
      if (acq_cnt != '0) acq_cnt <= acq_cnt - 1'b1;
    end
  end

endmodule

// File: rtl/adc_hc_seq.sv
module adc_hc_seq
  import adc_hc_pkg::*;
#(
  parameter int NCH      = 6,
  parameter int SLOT     = 16,
  parameter int CONV_HI  = 2,
  parameter int SCK_HALF = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic [2:0] sel,
  output logic       conv,
  output logic       sck,
  output logic       sample,
  output logic       done,
  output logic       idle
);
  localparam int EW   = $clog2(SLOT * NCH + 1);
  localparam int CMAX = (CONV_HI > SCK_HALF) ? CONV_HI : SCK_HALF;
  localparam int CW   = $clog2(CMAX + 1);

  seq_state_t    st;
  logic [CW-1:0] cnt;
  logic [EW-1:0] edges;
  logic [EW-1:0] total;

  assign total  = EW'(SLOT * chan_count(sel, NCH));
  assign sample = (st == SQ_BURST) && (cnt == '0) && !sck;
  assign done   = (st == SQ_DONE);
  assign idle   = (st == SQ_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= SQ_IDLE;
      conv  <= 1'b0;
      sck   <= 1'b0;
      cnt   <= '0;
      edges <= '0;
    end else begin
      unique case (st)
        SQ_IDLE: if (go) begin
          st    <= SQ_CONV;
          conv  <= 1'b1;
          cnt   <= CW'(CONV_HI - 1);
          edges <= '0;
        end
        SQ_CONV: if (cnt == '0) begin
          conv <= 1'b0;
          st   <= SQ_BURST;
          cnt  <= CW'(SCK_HALF - 1);
        end else begin
          cnt <= cnt - 1'b1;
        end
        SQ_BURST: if (cnt != '0) begin
          cnt <= cnt - 1'b1;
        end else begin
          cnt <= CW'(SCK_HALF - 1);
          if (!sck) begin
            sck   <= 1'b1;
            edges <= edges + 1'b1;
          end else begin
            sck <= 1'b0;
            if (edges == total) st <= SQ_DONE;
          end
        end
        SQ_DONE: st <= SQ_IDLE;
        default: st <= SQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/adc_hc_deser.sv
module adc_hc_deser #(
  parameter int NCH  = 6,
  parameter int W    = 12,
  parameter int SLOT = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             sample,
  input  logic             sdo,
  output logic [NCH*W-1:0] words
);
  localparam int BW = $clog2(SLOT);
  localparam int SW = $clog2(NCH + 1);

  logic [BW-1:0] bcnt;
  logic [SW-1:0] slot;
  logic [W-1:0]  sh;
  logic [W-1:0]  nxt;

  assign nxt = {sh[W-2:0], sdo};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcnt <= '0;
      slot <= '0;
      sh   <= '0;
    end else if (clear) begin
      bcnt <= '0;
      slot <= '0;
      sh   <= '0;
    end else if (sample) begin
      if (int'(bcnt) < W) sh <= nxt;
      if (int'(bcnt) == SLOT - 1) begin
        bcnt <= '0;
        slot <= slot + 1'b1;
      end else begin
        bcnt <= bcnt + 1'b1;
      end
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        words[g*W +: W] <= '0;
      end else if (clear) begin
        words[g*W +: W] <= '0;
      end else if (sample && int'(bcnt) == W - 1 && slot == SW'(g)) begin
        words[g*W +: W] <= nxt;
      end
    end
  end

endmodule

// File: rtl/adc_host_ctl.sv
module adc_host_ctl
  import adc_hc_pkg::*;
#(
  parameter int NCH      = 6,
  parameter int W        = 12,
  parameter int SLOT     = 16,
  parameter int CONV_HI  = 2,
  parameter int SCK_HALF = 1,
  parameter int ACQ_WAIT = 40
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start_req,
  input  logic [2:0]                 cfg_sel,
  input  logic                       cfg_bip,
  output logic                       busy,
  output logic                       adc_conv,
  output logic                       adc_sck,
  input  logic                       adc_sdo,
  output logic [2:0]                 adc_sel,
  output logic                       adc_bip,
  output logic                       frm_valid,
  input  logic                       frm_ready,
  output logic [NCH*W-1:0]           frm_data,
  output logic [$clog2(NCH+1)-1:0]   frm_nch,
  output logic                       frm_bip
);
  localparam int NW = $clog2(NCH + 1);

  adc_cfg_t         req;
  adc_cfg_t         act;
  logic             primed;
  logic             hold;
  logic             seq_idle;
  logic             seq_done;
  logic             sample;
  logic             go;
  logic [NCH*W-1:0] words;

  assign req     = '{sel: cfg_sel, bip: cfg_bip};
  assign go      = seq_idle && start_req && !hold && !frm_valid;
  assign busy    = !seq_idle;
  assign adc_sel = act.sel;
  assign adc_bip = act.bip;

  adc_hc_cfg #(.ACQ_WAIT(ACQ_WAIT)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .seq_idle  (seq_idle),
    .conv_done (seq_done),
    .act       (act),
    .primed    (primed),
    .hold      (hold)
  );

  adc_hc_seq #(
    .NCH      (NCH),
    .SLOT     (SLOT),
    .CONV_HI  (CONV_HI),
    .SCK_HALF (SCK_HALF)
  ) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .go     (go),
    .sel    (act.sel),
    .conv   (adc_conv),
    .sck    (adc_sck),
    .sample (sample),
    .done   (seq_done),
    .idle   (seq_idle)
  );

  adc_hc_deser #(.NCH(NCH), .W(W), .SLOT(SLOT)) u_deser (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (go),
    .sample (sample),
    .sdo    (adc_sdo),
    .words  (words)
  );

  // output holding register: a frame waits here until accepted
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frm_valid <= 1'b0;
      frm_data  <= '0;
      frm_nch   <= '0;
      frm_bip   <= 1'b0;
    end else if (seq_done && primed) begin
      frm_valid <= 1'b1;
      frm_data  <= words;
      frm_nch   <= NW'(chan_count(act.sel, NCH));
      frm_bip   <= act.bip;
    end else if (frm_valid && frm_ready) begin
      frm_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/adc_host_ctl_chk.sv
module adc_host_ctl_chk #(
  parameter int NCH      = 6,
  parameter int W        = 12,
  parameter int ACQ_WAIT = 40
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             adc_conv,
  input logic             adc_sck,
  input logic [2:0]       adc_sel,
  input logic             adc_bip,
  input logic             frm_valid,
  input logic             frm_ready,
  input logic [NCH*W-1:0] frm_data
);
  localparam int SW = $clog2(ACQ_WAIT + 2);

  logic [SW-1:0] since_bip;
  logic [1:0]    n_done;
  logic [2:0]    prev_sel;
  logic          prev_bip;
  logic          prev_busy;
  logic          cfg_moved;

  assign cfg_moved = (adc_sel != prev_sel) || (adc_bip != prev_bip);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_bip <= SW'(ACQ_WAIT);
      n_done    <= 2'd2;
      prev_sel  <= '0;
      prev_bip  <= 1'b0;
      prev_busy <= 1'b0;
    end else begin
      prev_sel  <= adc_sel;
      prev_bip  <= adc_bip;
      prev_busy <= busy;
      if (adc_bip != prev_bip) since_bip <= '0;
      else if (since_bip != SW'(ACQ_WAIT)) since_bip <= since_bip + 1'b1;
      if (cfg_moved) n_done <= 2'd0;
      else if (prev_busy && !busy && n_done != 2'd2) n_done <= n_done + 2'd1;
    end
  end

  // R5
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && prev_busy |-> !cfg_moved);

  // R5
  cfg_two_conv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_moved |-> n_done == 2'd2);

  // R6
  acq_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_conv) |-> since_bip == SW'(ACQ_WAIT));

  // R7
  frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid && !frm_ready |=> frm_valid && $stable(frm_data));

  // R7
  no_conv_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_conv) |-> !$past(frm_valid));

  // R8
  conv_sck_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(adc_conv && adc_sck));

  // R8
  sck_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !adc_sck);

endmodule

bind adc_host_ctl adc_host_ctl_chk #(
  .NCH      (NCH),
  .W        (W),
  .ACQ_WAIT (ACQ_WAIT)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .adc_conv  (adc_conv),
  .adc_sck   (adc_sck),
  .adc_sel   (adc_sel),
  .adc_bip   (adc_bip),
  .frm_valid (frm_valid),
  .frm_ready (frm_ready),
  .frm_data  (frm_data)
);

// File: tb/adc_host_ctl_test.sv
`timescale 1ns/1ps
module adc_host_ctl_test;
  localparam int NCH = 6;
  localparam int W   = 12;
  localparam int ACQ = 40;
  localparam int CHI = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_req = 1'b0;
  logic [2:0] cfg_sel = 3'd0;
  logic cfg_bip = 1'b0;
  logic busy, adc_conv, adc_sck, adc_bip, frm_valid, frm_bip;
  logic adc_sdo = 1'b0;
  logic [2:0] adc_sel, frm_nch;
  logic frm_ready = 1'b1;
  logic [NCH*W-1:0] frm_data;

  always #2 clk = ~clk;

  adc_host_ctl #(.NCH(NCH), .W(W), .CONV_HI(CHI), .ACQ_WAIT(ACQ)) uut (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .cfg_sel(cfg_sel),
    .cfg_bip(cfg_bip), .busy(busy), .adc_conv(adc_conv), .adc_sck(adc_sck),
    .adc_sdo(adc_sdo), .adc_sel(adc_sel), .adc_bip(adc_bip),
    .frm_valid(frm_valid), .frm_ready(frm_ready), .frm_data(frm_data),
    .frm_nch(frm_nch), .frm_bip(frm_bip)
  );

  int checks = 0;
  int failures = 0;

  // converter stub: returns the previous conversion's samples
  logic [W-1:0] ana  [NCH];
  logic [W-1:0] held [NCH];
  logic [W-1:0] outw [NCH];
  int bitpos = 0;

  function automatic logic bit_at(input int pos);
    int s, b;
    s = pos / 16;
    b = pos % 16;
    if (s >= NCH || b >= W) return 1'b0;
    return outw[s][W-1-b];
  endfunction

  initial for (int i = 0; i < NCH; i++) begin
    held[i] = '0; outw[i] = '0; ana[i] = '0;
  end

  always @(posedge adc_conv) begin
    for (int i = 0; i < NCH; i++) begin
      outw[i] = held[i];
      held[i] = ana[i];
    end
    bitpos = 0;
    adc_sdo = bit_at(0);
  end

  always @(posedge adc_sck) begin
    bitpos = bitpos + 1;
    adc_sdo = bit_at(bitpos);
  end

  // monitors
  int sck_cnt = 0, conv_w = 0, gap = 1000, cyc_since = 1000;
  int overlap = 0, frames = 0, conv_rises = 0;
  logic prev_bip_tb = 1'b0, prev_conv_tb = 1'b0;
  logic [NCH*W-1:0] last_frame = '0;
  logic [2:0] last_nch = '0;
  logic last_bip = 1'b0;

  always @(posedge adc_sck) sck_cnt++;

  always @(negedge clk) begin
    if (adc_conv) conv_w++;
    if ((adc_conv && adc_sck) || (!busy && adc_sck)) overlap++;
    if (adc_bip != prev_bip_tb) cyc_since = 0; else cyc_since++;
    if (adc_conv && !prev_conv_tb) begin
      gap = cyc_since;
      conv_rises++;
    end
    prev_bip_tb = adc_bip;
    prev_conv_tb = adc_conv;
    if (frm_valid && frm_ready) begin
      frames++;
      last_frame = frm_data;
      last_nch = frm_nch;
      last_bip = frm_bip;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load(input int base);
    for (int i = 0; i < NCH; i++) ana[i] = W'(base + 16'h111 * i + 7);
  endtask

  task automatic do_conv();
    @(negedge clk);
    sck_cnt = 0;
    conv_w = 0;
    start_req = 1'b1;
    wait (adc_conv === 1'b1);
    @(negedge clk);
    start_req = 1'b0;
    wait (busy === 1'b0);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic chk_frame(input string req, input int base, input int n);
    for (int i = 0; i < NCH; i++) begin
      logic [W-1:0] e;
      e = (i < n) ? W'(base + 16'h111 * i + 7) : '0;
      chk(last_frame[i*W +: W] == e, req, last_frame[i*W +: W], e);
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(!adc_conv && !adc_sck && !busy && !frm_valid, "R1", {adc_conv, adc_sck, busy, frm_valid}, 0);
    chk(adc_sel == 3'd0 && adc_bip == 1'b0, "R1", {adc_sel, adc_bip}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !adc_conv, "R1", busy, 0);
  endtask

  task automatic t_full();
    int f0;
    cfg_sel = 3'd5;
    load(12'h100);
    f0 = frames;
    do_conv();                          // config applied with the start: discard
    chk(frames == f0, "R4", frames - f0, 0);
    chk(conv_w == CHI, "R2", conv_w, CHI);
    chk(sck_cnt == 96, "R2", sck_cnt, 96);
    load(12'h200);
    do_conv();
    chk(frames == f0 + 1, "R4", frames - f0, 1);
    chk_frame("R3", 12'h100, 6);
    chk(last_nch == 3'd6 && last_bip == 1'b0, "R9", {last_nch, last_bip}, 12);
  endtask

  task automatic t_defer();
    int f0;
    cfg_sel = 3'd2;
    load(12'h300);
    f0 = frames;
    do_conv();
    chk(sck_cnt == 48, "R2", sck_cnt, 48);
    chk(frames == f0, "R4", frames - f0, 0);
    cfg_sel = 3'd0;                     // only one conversion done: deferred
    load(12'h400);
    do_conv();
    chk(sck_cnt == 48, "R5", sck_cnt, 48);
    chk(frames == f0 + 1, "R4", frames - f0, 1);
    chk_frame("R3", 12'h300, 3);
    chk(last_nch == 3'd3, "R9", last_nch, 3);
    load(12'h500);
    do_conv();
    chk(adc_sel == 3'd0, "R5", adc_sel, 0);
    chk(sck_cnt == 16, "R2", sck_cnt, 16);
    chk(frames == f0 + 1, "R4", frames - f0, 1);
    load(12'h600);
    do_conv();
    chk_frame("R3", 12'h500, 1);
  endtask

  task automatic t_bip();
    int f0;
    cfg_sel = 3'd7;
    cfg_bip = 1'b1;
    load(12'h700);
    f0 = frames;
    do_conv();
    chk(gap >= ACQ, "R6", gap, ACQ);
    chk(sck_cnt == 96, "R2", sck_cnt, 96);
    chk(frames == f0, "R4", frames - f0, 0);
    load(12'h800);
    do_conv();
    chk_frame("R3", 12'h700, 6);
    chk(last_bip == 1'b1 && last_nch == 3'd6, "R9", {last_nch, last_bip}, 13);
  endtask

  task automatic t_backpressure();
    logic [NCH*W-1:0] snap;
    int r0, moved;
    frm_ready = 1'b0;
    load(12'h900);
    do_conv();
    chk(frm_valid == 1'b1, "R7", frm_valid, 1);
    snap = frm_data;
    r0 = conv_rises;
    moved = 0;
    load(12'ha00);
    start_req = 1'b1;
    repeat (60) begin
      @(negedge clk);
      if (frm_data != snap || !frm_valid) moved++;
    end
    chk(conv_rises == r0, "R7", conv_rises - r0, 0);
    chk(moved == 0, "R7", moved, 0);
    frm_ready = 1'b1;
    wait (adc_conv === 1'b1);
    @(negedge clk);
    start_req = 1'b0;
    chk_frame("R7", 12'h800, 6);
    wait (busy === 1'b0);
    @(negedge clk);
    @(negedge clk);
    chk_frame("R4", 12'h900, 6);
    chk(overlap == 0, "R8", overlap, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_full();
    t_defer();
    t_bip();
    t_backpressure();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule